// File: doc/BRIEF.md
# Configurable Dual-Table Logic Slice

This block is one logic cell of a fabric model. It holds two 4-input lookup tables and two storage flops. A configuration word sets the contents of both tables, chooses between two independent 4-input functions and one 5-input function, and sets up each flop. For each flop the word selects the data source, whether the clock enable comes from a pin or is tied high, the value applied by set/reset, whether set/reset acts at once or at the clock edge, and whether the set/reset pin is used at all.

The word is captured on a clock edge while `cfg_en` is high. Until the first capture every output is held at zero. Two slice kinds are built from the `SLICE_KIND` parameter, and they differ only in where each flop takes its data by default. Kind 0 takes the table output of its own half and moves to the combined 5-input result when the half's alternate-route bit is set. Kind 1 takes the bypass input of its own half and moves to the table output when that bit is set.

Top module: `lslice_top`

## Requirements
- R1: After reset and before any configuration capture, `f_out`, `fx_out` and `q_out` are all zero, whatever the other inputs are.
- R2: `cfg_word` is captured at a rising edge where `cfg_en` is 1. The bit layout is: [15:0] table 0, [31:16] table 1, [32] wide mode. Flop 0 uses [37:33] and flop 1 uses [42:38], and each 5-bit field is {srpin_en, sr_sync, sr_val, cepin_en, alt} with alt in the lowest bit. At that same edge each flop takes its sr_val.
- R3: In narrow mode (bit 32 = 0), `f_out[0]` equals table0[`lut_a`] and `f_out[1]` equals table1[`lut_b`]. Bit 0 of the index is input a, so two-input OR is 16'hEEEE, XOR is 16'h6666 and NOR is 16'h1111.
- R4: In wide mode, both tables are indexed by `lut_a`, and `fx_out` equals `f_out[1]` when `byp[0]` is 1 and `f_out[0]` when `byp[0]` is 0.
- R5: In kind 0, flop h loads `f_out[h]` when its alt bit is 0 and `fx_out` when its alt bit is 1.
- R6: In kind 1, flop h loads `byp[h]` when its alt bit is 0 and `f_out[h]` when its alt bit is 1.
- R7: With cepin_en = 0 a flop loads at every edge. With cepin_en = 1 it loads only when `ce_in` is 1 and otherwise holds its value.
- R8: With srpin_en = 1 and sr_sync = 0, raising `sr_in` drives the flop output to sr_val at once, with no clock edge. The flop keeps sr_val while `sr_in` stays high.
- R9: With srpin_en = 1 and sr_sync = 1, `sr_in` takes effect only at the next rising edge. At that edge it loads sr_val, even when `ce_in` is 0.
- R10: With srpin_en = 0, `sr_in` has no effect, and the flop keeps following its data source.
- R11: Driving `rst_n` low clears the configuration and all outputs immediately. After release the block returns to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Capture `cfg_word` at this edge |
| cfg_word | input | 43 | Flat configuration word |
| lut_a | input | 4 | Inputs of table 0 (and of table 1 in wide mode) |
| lut_b | input | 4 | Inputs of table 1 in narrow mode |
| byp | input | 2 | Bypass input per half; bit 0 also picks the wide result |
| ce_in | input | 1 | Shared clock-enable pin |
| sr_in | input | 1 | Shared set/reset pin |
| f_out | output | 2 | Combinational table outputs |
| fx_out | output | 1 | Combined 5-input result |
| q_out | output | 2 | Flop outputs |

## Verification
The assertions are checked on every cycle. They cover the zero outputs before configuration, the rule that the valid state begins only at a capture, and the loading of sr_val at capture. They also cover the flop holding when its enable is off and no set/reset is pending, and the edge-time effect of an active set/reset in either mode. The bench has to show the rest: the table contents against a truth-table model for every input pattern in both modes and both kinds, the per-kind data routing, the immediate (unclocked) effect of asynchronous set/reset, and the fact that a disabled set/reset pin does nothing.

// File: rtl/lslice_pkg.sv
package lslice_pkg;
  localparam int LUT_K = 4;
  localparam int TBL_W = 1 << LUT_K;
  localparam int HALVES = 2;

  typedef struct packed {
    logic srpin_en;
    logic sr_sync;
    logic sr_val;
    logic cepin_en;
    logic alt;
  } ff_cfg_t;

  typedef struct packed {
    ff_cfg_t            ff1;
    ff_cfg_t            ff0;
    logic               wide;
    logic [TBL_W-1:0]   tbl1;
    logic [TBL_W-1:0]   tbl0;
  } slice_cfg_t;

  localparam int CFG_W = $bits(slice_cfg_t);
endpackage

// File: rtl/lslice_rst_sync.sv
module lslice_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/lslice_lut.sv
module lslice_lut #(
  parameter int K = 4,
  localparam int W = 1 << K
) (
  input  logic [W-1:0] tbl,
  input  logic [K-1:0] sel,
  output logic         o
);
  always_comb o = tbl[sel];
endmodule

// File: rtl/lslice_ff.sv
module lslice_ff (
  input  logic clk,
  input  logic rst_s_n,
  input  logic load,
  input  logic load_val,
  input  logic valid,
  input  logic cepin_en,
  input  logic srpin_en,
  input  logic sr_sync,
  input  logic sr_val,
  input  logic d,
  input  logic ce_in,
  input  logic sr_in,
  output logic q
);
  logic q_reg, q_nxt, ce_eff, sr_act;

  always_comb begin
    ce_eff = cepin_en ? ce_in : 1'b1;
    sr_act = valid & srpin_en & sr_in;
    q_nxt  = q_reg;
    if (load)        q_nxt = load_val;
    else if (sr_act) q_nxt = sr_val;
    else if (valid && ce_eff) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) q_reg <= 1'b0;
    else          q_reg <= q_nxt;
  end

  assign q = (sr_act && !sr_sync) ? sr_val : q_reg;

  a_r2_load_init: assert property (@(posedge clk) disable iff (!rst_s_n)
    load |=> (q_reg == $past(load_val)));

  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load && valid && cepin_en && !ce_in && !(srpin_en && sr_in)) |=> $stable(q_reg));

  a_r9_sr_at_edge: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load && valid && srpin_en && sr_in) |=> (q_reg == $past(sr_val)));
endmodule

// File: rtl/lslice_top.sv
module lslice_top
  import lslice_pkg::*;
#(
  parameter int SLICE_KIND = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [LUT_K-1:0] lut_a,
  input  logic [LUT_K-1:0] lut_b,
  input  logic [1:0]       byp,
  input  logic             ce_in,
  input  logic             sr_in,
  output logic [1:0]       f_out,
  output logic             fx_out,
  output logic [1:0]       q_out
);
  logic       rst_s_n;
  slice_cfg_t cfg_q, cfg_d, cfg_new;
  logic       valid_q, valid_d;

  lslice_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  assign cfg_new = slice_cfg_t'(cfg_word);

  always_comb begin
    cfg_d   = cfg_q;
    valid_d = valid_q;
    if (cfg_en) begin
      cfg_d   = cfg_new;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      valid_q <= valid_d;
    end
  end

  logic [LUT_K-1:0] lsel [HALVES];
  logic [TBL_W-1:0] ltbl [HALVES];
  ff_cfg_t          ffc  [HALVES];
  logic             ldv  [HALVES];
  logic [1:0]       f_raw, q_raw, dsel;
  logic             fx_raw;

  assign lsel[0] = lut_a;
  assign lsel[1] = cfg_q.wide ? lut_a : lut_b;
  assign ltbl[0] = cfg_q.tbl0;
  assign ltbl[1] = cfg_q.tbl1;
  assign ffc[0]  = cfg_q.ff0;
  assign ffc[1]  = cfg_q.ff1;
  assign ldv[0]  = cfg_new.ff0.sr_val;
  assign ldv[1]  = cfg_new.ff1.sr_val;

  assign fx_raw = byp[0] ? f_raw[1] : f_raw[0];

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    lslice_lut #(.K(LUT_K)) u_lut (
      .tbl(ltbl[h]), .sel(lsel[h]), .o(f_raw[h])
    );

    if (SLICE_KIND == 0) begin : g_kind0
      assign dsel[h] = ffc[h].alt ? fx_raw : f_raw[h];
    end else begin : g_kind1
      assign dsel[h] = ffc[h].alt ? f_raw[h] : byp[h];
    end

    lslice_ff u_ff (
      .clk(clk), .rst_s_n(rst_s_n), .load(cfg_en), .load_val(ldv[h]),
      .valid(valid_q), .cepin_en(ffc[h].cepin_en), .srpin_en(ffc[h].srpin_en),
      .sr_sync(ffc[h].sr_sync), .sr_val(ffc[h].sr_val), .d(dsel[h]),
      .ce_in(ce_in), .sr_in(sr_in), .q(q_raw[h])
    );
  end

  assign f_out  = valid_q ? f_raw : 2'b00;
  assign fx_out = valid_q & fx_raw;
  assign q_out  = q_raw;

  a_r1_quiet_unconfigured: assert property (@(posedge clk) disable iff (!rst_s_n)
    !valid_q |-> (q_out == 2'b00 && f_out == 2'b00 && !fx_out));

  a_r2_valid_from_capture: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(valid_q) |-> $past(cfg_en));
endmodule

// File: tb/lslice_top_bench.sv
module lslice_top_bench;
  logic        clk = 1'b0;
  logic        rst_n, cfg_en, ce_in, sr_in;
  logic [42:0] cfg_word;
  logic [3:0]  lut_a, lut_b;
  logic [1:0]  byp;
  logic [1:0]  f1o, q1o, f0o, q0o;
  logic        fx1o, fx0o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  lslice_top #(.SLICE_KIND(1)) u_lslice_top (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_word(cfg_word),
    .lut_a(lut_a), .lut_b(lut_b), .byp(byp), .ce_in(ce_in), .sr_in(sr_in),
    .f_out(f1o), .fx_out(fx1o), .q_out(q1o));

  lslice_top #(.SLICE_KIND(0)) u_lslice_top_k0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_word(cfg_word),
    .lut_a(lut_a), .lut_b(lut_b), .byp(byp), .ce_in(ce_in), .sr_in(sr_in),
    .f_out(f0o), .fx_out(fx0o), .q_out(q0o));

  // rows: {wide, tbl1, tbl0}
  localparam logic [32:0] VEC [5] = '{
    {1'b0, 16'hEEEE, 16'h6666},
    {1'b0, 16'h8000, 16'h1111},
    {1'b1, 16'h00FF, 16'hF0F0},
    {1'b1, 16'h9669, 16'h6996},
    {1'b0, 16'h1E78, 16'hA5C3}
  };

  // ff field: {srpin_en, sr_sync, sr_val, cepin_en, alt}
  function automatic logic [42:0] mk(input logic [15:0] t0, input logic [15:0] t1,
                                     input logic w, input logic [4:0] c0, input logic [4:0] c1);
    return {c1, c0, w, t1, t0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [42:0] w);
    @(negedge clk); cfg_en = 1'b1; cfg_word = w;
    @(negedge clk); cfg_en = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic e0, e1;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_word = '0; lut_a = 4'hF; lut_b = 4'hF;
    byp = 2'b11; ce_in = 1'b1; sr_in = 1'b1;
    #23;
    chk("R11 in reset", {f1o, fx1o, q1o}, 8'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 unconfigured k1", {f1o, fx1o, q1o}, 8'h0);
    chk("R1 unconfigured k0", {f0o, fx0o, q0o}, 8'h0);
    sr_in = 1'b0;

    // truth-table sweep, R3 and R4
    for (int e = 0; e < 5; e++) begin
      load_cfg(mk(VEC[e][15:0], VEC[e][31:16], VEC[e][32], 5'b0, 5'b0));
      for (int v = 0; v < 512; v++) begin
        lut_a = v[3:0]; lut_b = v[7:4]; byp = {1'b0, v[8]};
        #2;
        e0 = VEC[e][lut_a];
        e1 = VEC[e][32] ? VEC[e][16 + lut_a] : VEC[e][16 + lut_b];
        if (VEC[e][32]) begin
          chk("R4 f k1", {6'b0, f1o}, {6'b0, e1, e0});
          chk("R4 f k0", {6'b0, f0o}, {6'b0, e1, e0});
          chk("R4 fx k1", {7'b0, fx1o}, {7'b0, v[8] ? e1 : e0});
          chk("R4 fx k0", {7'b0, fx0o}, {7'b0, v[8] ? e1 : e0});
        end else begin
          chk("R3 f k1", {6'b0, f1o}, {6'b0, e1, e0});
          chk("R3 f k0", {6'b0, f0o}, {6'b0, e1, e0});
        end
      end
    end

    // data routing, R5 and R6: f0 = a, f1 = b
    load_cfg(mk(16'hAAAA, 16'hCCCC, 1'b1, 5'b00000, 5'b00000));
    lut_a = 4'b0001; byp = 2'b10;
    @(negedge clk);
    chk("R5 alt0 k0", {6'b0, q0o}, 8'b01);
    chk("R6 alt0 k1", {6'b0, q1o}, 8'b10);
    load_cfg(mk(16'hAAAA, 16'hCCCC, 1'b1, 5'b00001, 5'b00001));
    chk("R2 init zero", {6'b0, q0o}, 8'b00);
    lut_a = 4'b0001; byp = 2'b10;
    @(negedge clk);
    chk("R5 alt1 k0", {6'b0, q0o}, 8'b11);
    chk("R6 alt1 k1", {6'b0, q1o}, 8'b01);
    byp = 2'b01;
    @(negedge clk);
    chk("R5 alt1 fx=f1 k0", {6'b0, q0o}, 8'b00);
    chk("R6 alt1 k1 b", {6'b0, q1o}, 8'b01);

    // R7 clock enable from pin
    load_cfg(mk(16'hAAAA, 16'h0000, 1'b1, 5'b00010, 5'b00010));
    lut_a = 4'b0001; byp = 2'b00; ce_in = 1'b0;
    @(negedge clk); chk("R7 ce low holds", {7'b0, q0o[0]}, 8'd0);
    ce_in = 1'b1;
    @(negedge clk); chk("R7 ce high loads", {7'b0, q0o[0]}, 8'd1);
    ce_in = 1'b0; lut_a = 4'b0000;
    @(negedge clk); chk("R7 ce low keeps 1", {7'b0, q0o[0]}, 8'd1);

    // R8 asynchronous set/reset
    load_cfg(mk(16'hAAAA, 16'h0000, 1'b1, 5'b10000, 5'b00000));
    lut_a = 4'b0001; sr_in = 1'b0;
    @(negedge clk); chk("R8 pre data", {7'b0, q0o[0]}, 8'd1);
    sr_in = 1'b1; #1;
    chk("R8 immediate", {7'b0, q0o[0]}, 8'd0);
    @(negedge clk); chk("R8 held", {7'b0, q0o[0]}, 8'd0);
    sr_in = 1'b0;
    @(negedge clk); chk("R8 released", {7'b0, q0o[0]}, 8'd1);

    // R9 synchronous set/reset, wins over clock enable
    load_cfg(mk(16'hAAAA, 16'h0000, 1'b1, 5'b11010, 5'b11010));
    lut_a = 4'b0001; ce_in = 1'b1;
    @(negedge clk); chk("R9 pre data", {7'b0, q0o[0]}, 8'd1);
    sr_in = 1'b1; ce_in = 1'b0; #1;
    chk("R9 not immediate", {7'b0, q0o[0]}, 8'd1);
    @(negedge clk); chk("R9 at edge", {7'b0, q0o[0]}, 8'd0);
    sr_in = 1'b0;
    @(negedge clk); chk("R9 hold after", {7'b0, q0o[0]}, 8'd0);
    load_cfg(mk(16'hAAAA, 16'h0000, 1'b1, 5'b11110, 5'b11110));
    chk("R2 init set k0", {6'b0, q0o}, 8'b11);
    chk("R2 init set k1", {6'b0, q1o}, 8'b11);
    lut_a = 4'b0000; ce_in = 1'b1;
    @(negedge clk); chk("R9 data 0", {7'b0, q0o[0]}, 8'd0);
    sr_in = 1'b1;
    @(negedge clk); chk("R9 set value", {7'b0, q0o[0]}, 8'd1);
    sr_in = 1'b0;

    // R10 set/reset pin disabled
    load_cfg(mk(16'hAAAA, 16'h0000, 1'b1, 5'b00000, 5'b00000));
    lut_a = 4'b0001; sr_in = 1'b1; #1;
    chk("R10 no async effect", {7'b0, q0o[0]}, 8'd0);
    @(negedge clk); chk("R10 data still loads", {7'b0, q0o[0]}, 8'd1);
    sr_in = 1'b0;

    // R11 reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R11 immediate clear k0", {f0o, fx0o, q0o}, 8'h0);
    chk("R11 immediate clear k1", {f1o, fx1o, q1o}, 8'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 back to R1", {f0o, fx0o, q0o}, 8'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule